// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is the read side of a mask-style read-only store that can be wired for two access widths. A static width input picks the view. In word view the port returns full 16-bit words. In byte view it returns single bytes, and the array holds twice as many locations. In byte view one extra input supplies the lowest address bit. That same pin carries the top data bit when the port runs in word view. The contents are produced by a fixed arithmetic function of the word index, so any consumer or checker can predict every location without a content file.

Reads are registered. The request presented at a rising edge (address, lane select, enables, width) appears on the outputs until the next edge. Each output lane has its own drive flag that stands in for a three-state buffer. A lane's data is forced to zero whenever its flag is low. A standby flag marks cycles in which the chip enable was inactive. The reset is asynchronous and active low, and its release is synchronised to the clock through two flops.

Top module: `dual_width_rom_port`

## Requirements
- R1: In byte view (`wide_mode`=0) with both enables low, the byte address is {`addr`, `sub_lsb`}. `sub_lsb`=0 puts bits [7:0] of the addressed word on `lo_data`, and `sub_lsb`=1 puts bits [15:8] there. `lo_oe`=1.
- R2: In byte view, `hi_oe` is 0 and `hi_data` is 0 in every cycle, so the shared pin stays an input.
- R3: In word view (`wide_mode`=1) with both enables low, `lo_data` carries word bits [7:0] and `hi_data` carries word bits [15:8], with `hi_data[7]` being data bit 15. Both `lo_oe` and `hi_oe` are 1.
- R4: In word view, `sub_lsb` has no effect on any output.
- R5: When `chip_en_n` is 1, `standby`=1, both drive flags are 0 and both data lanes are 0, whatever the other inputs are.
- R6: When `chip_en_n`=0 and `out_en_n`=1, `standby`=0, both drive flags are 0 and both data lanes are 0.
- R7: The outputs in the cycle after a rising edge reflect exactly the inputs sampled at that edge, which is one cycle of latency.
- R8: While reset is applied, and for the two edges after it is released, `standby`=1 and all drive flags and data are 0.
- R9: `wide_mode` is only changed while reset is applied. A change after reset is flagged by an assertion. A width chosen during reset governs all reads that follow.
- R10: Word index w holds ((w × 16'h9E37) mod 2^16) XOR 16'h5AC3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Width select: 0 byte view, 1 word view |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | WORD_AW | Word index |
| sub_lsb | input | 1 | Byte-view lowest address bit (shared pin, input side) |
| lo_data | output | 8 | Low data lane, bits 7..0 |
| lo_oe | output | 1 | Low lane drive flag |
| hi_data | output | 8 | High data lane, bits 15..8 (bit 7 is the shared pin's output side) |
| hi_oe | output | 1 | High lane drive flag |
| standby | output | 1 | Chip enable was inactive at the last edge |

## Verification
Two functions can land in the same cycle: the lane selection tied to the address and width, and the enable gating that can blank that lane. The bench changes `addr`, `sub_lsb`, `chip_en_n` and `out_en_n` together on every cycle from a shift-register sequence. As a result, a lane-select flip often meets an enable release or withdrawal at the same edge. A behavioural model compares every output on every clock. A stale select under a fresh enable shows up as the wrong byte, and a stale enable shows up as a lane driving or blanking one cycle off.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef enum logic {
    VIEW_BYTE = 1'b0,
    VIEW_WORD = 1'b1
  } width_view_e;

  typedef struct packed {
    logic        active;   // chip enabled at the sampling edge
    logic        drive;    // output enable asserted at the sampling edge
    width_view_e view;
    logic        hi_sel;   // byte view: take upper half of the word
  } read_ctl_t;

  function automatic logic [WORD_W-1:0] pattern_word(
    input int unsigned       idx,
    input logic [WORD_W-1:0] mult,
    input logic [WORD_W-1:0] key
  );
    logic [31:0] prod;
    prod = idx * {16'd0, mult};
    return prod[WORD_W-1:0] ^ key;
  endfunction

endpackage

// File: rtl/rom_addr_former.sv
module rom_addr_former
  import rom_port_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  width_view_e        view,
  input  logic [WORD_AW-1:0] addr,
  input  logic               sub_lsb,
  output logic [WORD_AW-1:0] word_idx,
  output logic               hi_sel
);

  localparam int BYTE_AW = WORD_AW + 1;

  logic [BYTE_AW-1:0] byte_addr;

  always_comb begin
    byte_addr = {addr, sub_lsb};
    if (view == VIEW_BYTE) begin
      word_idx = byte_addr[BYTE_AW-1:1];
      hi_sel   = byte_addr[0];
    end else begin
      word_idx = addr;
      hi_sel   = 1'b0;
    end
  end

  // R4: the shared pin never reaches the lane select in word view
  always_comb begin
    if (view == VIEW_WORD) begin
      a_r4_word_ignores_lsb : assert (hi_sel == 1'b0);
    end
  end

endmodule

// File: rtl/rom_pattern_array.sv
module rom_pattern_array
  import rom_port_pkg::*;
#(
  parameter int                WORD_AW = 6,
  parameter logic [WORD_W-1:0] MULT    = 16'h9E37,
  parameter logic [WORD_W-1:0] KEY     = 16'h5AC3
) (
  input  logic [WORD_AW-1:0] word_idx,
  output logic [WORD_W-1:0]  word
);

  localparam int DEPTH = 1 << WORD_AW;

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells[g] = pattern_word(g, MULT, KEY);
  end

  assign word = cells[word_idx];

endmodule

// File: rtl/rom_lane_gate.sv
module rom_lane_gate
  import rom_port_pkg::*;
(
  input  read_ctl_t         ctl,
  input  logic [WORD_W-1:0] word,
  output logic [LANE_W-1:0] lo_data,
  output logic              lo_oe,
  output logic [LANE_W-1:0] hi_data,
  output logic              hi_oe,
  output logic              standby
);

  logic              lanes_on;
  logic [LANE_W-1:0] picked;

  always_comb begin
    lanes_on = ctl.active & ctl.drive;
    picked   = ctl.hi_sel ? word[WORD_W-1:LANE_W] : word[LANE_W-1:0];
    standby  = ~ctl.active;
    lo_oe    = lanes_on;
    hi_oe    = lanes_on & (ctl.view == VIEW_WORD);
    lo_data  = '0;
    hi_data  = '0;
    if (lanes_on) begin
      if (ctl.view == VIEW_WORD) begin
        lo_data = word[LANE_W-1:0];
        hi_data = word[WORD_W-1:LANE_W];
      end else begin
        lo_data = picked;
      end
    end
  end

  // R2/R5/R6: an undriven lane always reads as zero
  always_comb begin
    a_r5_lo_quiet : assert (lo_oe || lo_data == '0);
    a_r2_hi_quiet : assert (hi_oe || hi_data == '0);
  end

endmodule

// File: rtl/dual_width_rom_port.sv
module dual_width_rom_port
  import rom_port_pkg::*;
#(
  parameter int                WORD_AW = 6,
  parameter logic [WORD_W-1:0] MULT    = 16'h9E37,
  parameter logic [WORD_W-1:0] KEY     = 16'h5AC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               chip_en_n,
  input  logic               out_en_n,
  input  logic [WORD_AW-1:0] addr,
  input  logic               sub_lsb,
  output logic [7:0]         lo_data,
  output logic               lo_oe,
  output logic [7:0]         hi_data,
  output logic               hi_oe,
  output logic               standby
);

  localparam int SYNC_STAGES = 2;

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  // next-state: form the request from the pins
  width_view_e        view_d;
  logic [WORD_AW-1:0] idx_d;
  logic               hi_sel_d;
  read_ctl_t          ctl_d;
  logic               idx_en;

  assign view_d = wide_mode ? VIEW_WORD : VIEW_BYTE;

  rom_addr_former #(.WORD_AW(WORD_AW)) i_former (
    .view     (view_d),
    .addr     (addr),
    .sub_lsb  (sub_lsb),
    .word_idx (idx_d),
    .hi_sel   (hi_sel_d)
  );

  always_comb begin
    ctl_d.active = ~chip_en_n;
    ctl_d.drive  = ~out_en_n;
    ctl_d.view   = view_d;
    ctl_d.hi_sel = hi_sel_d;
    idx_en       = ~chip_en_n;  // index only moves while selected
  end

  // registers
  read_ctl_t          ctl_q;
  logic [WORD_AW-1:0] idx_q;
  logic               armed_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q   <= '{active: 1'b0, drive: 1'b0, view: VIEW_BYTE, hi_sel: 1'b0};
      armed_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // array and lane gating
  logic [WORD_W-1:0] word;

  rom_pattern_array #(.WORD_AW(WORD_AW), .MULT(MULT), .KEY(KEY)) i_array (
    .word_idx (idx_q),
    .word     (word)
  );

  rom_lane_gate i_gate (
    .ctl     (ctl_q),
    .word    (word),
    .lo_data (lo_data),
    .lo_oe   (lo_oe),
    .hi_data (hi_data),
    .hi_oe   (hi_oe),
    .standby (standby)
  );

  // port-level properties
  a_r9_width_fixed : assert property (@(posedge clk) disable iff (!srst_n)
    armed_q |-> $stable(wide_mode));

  a_r5_standby : assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && $past(chip_en_n)) |-> (standby && !lo_oe && !hi_oe));

  a_r6_outputs_off : assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && $past(!chip_en_n && out_en_n)) |-> (!standby && !lo_oe && !hi_oe));

  a_r3_both_lanes : assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && $past(wide_mode && !chip_en_n && !out_en_n)) |-> (lo_oe && hi_oe));

  a_r2_byte_hi_idle : assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && $past(!wide_mode)) |-> (!hi_oe && hi_data == 8'h00));

  a_r1_byte_lo_on : assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && $past(!wide_mode && !chip_en_n && !out_en_n)) |-> lo_oe);

endmodule

// File: tb/test_dual_width_rom_port.sv
module test_dual_width_rom_port;

  localparam int AW = 6;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk;
  logic          rst_n;
  logic          wide_mode;
  logic          chip_en_n;
  logic          out_en_n;
  logic [AW-1:0] addr;
  logic          sub_lsb;
  logic [7:0]    lo_data;
  logic          lo_oe;
  logic [7:0]    hi_data;
  logic          hi_oe;
  logic          standby;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dual_width_rom_port #(.WORD_AW(AW)) i_dual_width_rom_port (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .addr(addr), .sub_lsb(sub_lsb), .lo_data(lo_data),
    .lo_oe(lo_oe), .hi_data(hi_data), .hi_oe(hi_oe), .standby(standby)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // R10 content, computed from the stated formula
  function automatic int ref_word(int w);
    return ((w * 40503) % 65536) ^ 16'h5AC3;
  endfunction

  // expected outputs
  logic [7:0] e_lo, e_hi;
  logic       e_lo_oe, e_hi_oe, e_sb;

  task automatic model(input logic m, input logic ce_n, input logic oe_n,
                       input int a, input logic x);
    int w;
    w = ref_word(a);
    e_lo = 8'h00; e_hi = 8'h00; e_lo_oe = 1'b0; e_hi_oe = 1'b0;
    e_sb = ce_n;
    if (!ce_n && !oe_n) begin
      e_lo_oe = 1'b1;
      if (m) begin
        e_hi_oe = 1'b1;
        e_lo = w[7:0];
        e_hi = w[15:8];
      end else begin
        e_lo = x ? w[15:8] : w[7:0];
      end
    end
  endtask

  task automatic compare(input string req);
    total++;
    if (lo_data !== e_lo || lo_oe !== e_lo_oe || hi_data !== e_hi ||
        hi_oe !== e_hi_oe || standby !== e_sb) begin
      bad++;
      $display("FAIL %s: got lo=%h/%b hi=%h/%b sb=%b expected lo=%h/%b hi=%h/%b sb=%b",
               req, lo_data, lo_oe, hi_data, hi_oe, standby,
               e_lo, e_lo_oe, e_hi, e_hi_oe, e_sb);
    end
  endtask

  // one cycle: drive at negedge, edge, then compare at next negedge (R7)
  task automatic cycle(input logic ce_n, input logic oe_n, input int a,
                       input logic x, input string req);
    chip_en_n = ce_n; out_en_n = oe_n; addr = a[AW-1:0]; sub_lsb = x;
    @(posedge clk);
    model(wide_mode, ce_n, oe_n, a, x);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    chip_en_n = 1'b0; out_en_n = 1'b0; addr = '1; sub_lsb = 1'b1;
    @(negedge clk);
    wide_mode = m;
    @(negedge clk);
    model(m, 1'b1, 1'b1, 0, 1'b0);
    compare("R8 in reset");
    rst_n = 1'b1;
    // two edges of synchronised release: still idle whatever the pins say
    @(posedge clk);
    @(negedge clk);
    compare("R8 release 1");
    chip_en_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R8 release 2");
  endtask

  logic [15:0] lfsr;

  task automatic mixed(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] & lfsr[5], lfsr[1] & lfsr[7], int'(lfsr[13:8]), lfsr[2], req);
    end
  endtask

  initial begin
    rst_n = 1'b0; wide_mode = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b1;
    addr = '0; sub_lsb = 1'b0; lfsr = 16'hACE1;

    // byte view
    do_reset(1'b0);
    cycle(1'b0, 1'b0, 5, 1'b0, "R9 byte view after reset");
    for (int b = 0; b < (2 << AW); b++)
      cycle(1'b0, 1'b0, b >> 1, b[0], "R1/R2/R7/R10 byte sweep");
    cycle(1'b1, 1'b0, 9, 1'b1, "R5 byte standby");
    cycle(1'b1, 1'b1, 9, 1'b0, "R5 byte standby both high");
    cycle(1'b0, 1'b1, 9, 1'b1, "R6 byte outputs off");
    cycle(1'b0, 1'b0, 63, 1'b1, "R1 top byte");
    cycle(1'b0, 1'b0, 0, 1'b0, "R1 bottom byte");
    mixed(300, "R1/R2/R5/R6 byte mixed");

    // word view
    do_reset(1'b1);
    cycle(1'b0, 1'b0, 5, 1'b0, "R9 word view after reset");
    for (int w = 0; w < (1 << AW); w++)
      cycle(1'b0, 1'b0, w, 1'b0, "R3/R7/R10 word sweep");
    for (int w = 0; w < (1 << AW); w += 7) begin
      cycle(1'b0, 1'b0, w, 1'b1, "R4 lsb high");
      cycle(1'b0, 1'b0, w, 1'b0, "R4 lsb low");
    end
    cycle(1'b1, 1'b0, 12, 1'b1, "R5 word standby");
    cycle(1'b0, 1'b1, 12, 1'b0, "R6 word outputs off");
    cycle(1'b0, 1'b0, 12, 1'b1, "R7 re-enable");
    mixed(300, "R3/R4/R5/R6 word mixed");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule